// File: doc/BRIEF.md
# Drift-Corrected Time-of-Day Counter for Precision Timestamping

This block keeps the time of day as a 32-bit seconds count and a 31-bit binary subseconds count. One subseconds unit is 2^-31 s. In fine mode, a 32-bit rate word is added to a 32-bit phase accumulator on every system clock. Whenever that sum overflows, the time moves forward by a programmable 8-bit step. Software can trim the rate word to cancel error in the system clock frequency. In coarse mode, the step is added on every clock and the accumulator is not used.

Software drives the block through a small register port: a write strobe, a read strobe with one cycle of latency, and a 3-bit address. Through it, software enables counting and selects fine or coarse mode. It stages a seconds/subseconds value and then asks for one of two actions: load that value as the new time, or apply it as a signed offset in a single step. It can also stage a new rate word and ask for it to be made active. Each request bit clears itself once its action is done. A read of the seconds word freezes the subseconds word at that same instant, so the two halves always form a matching pair.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time reads 0 s / 0 units, the control word (address 0) reads 0, and the active rate word (address 5) reads the parameter DEF_ADDEND (default 0x4000_0000).
- R2: With control bits run (bit 0) and fine (bit 1) both set, every clock adds the active rate word to the 32-bit accumulator, which starts at 0 after reset. The step (address 1, bits 7:0) is added to the time only on clocks where that sum overflows.
- R3: With run set and fine clear, the step is added to the time on every clock.
- R4: With run clear, the time does not advance in either mode.
- R5: When subseconds reach 2^31 they wrap, and the carry goes into seconds. Seconds wrap modulo 2^32.
- R6: Writing control bit 2 copies the staged seconds (address 2) and the staged subseconds bits 30:0 (address 3) into the time at the next clock, and the bit then reads back clear. Staged seconds and subseconds cannot be written while a load or offset request is pending.
- R7: Writing control bit 3 adds the staged value to the time, or subtracts it when bit 31 of the staged subseconds word is set. Bits 30:0 give the magnitude. Borrows and carries cross the seconds boundary, and the result subseconds stay within 0 to 2^31-1. The bit then reads back clear.
- R8: Writing control bit 4 moves the staged rate word (address 4) into the active rate word at the next clock, and the bit then reads back clear. A write to address 4 on the clock while this request is pending is ignored.
- R9: Reading address 6 returns seconds and freezes the subseconds of that same clock. Reading address 7 returns that frozen value until the next read of address 6.
- R10: When load and offset are requested in the same write, the load happens first and the offset is applied on the clock after it.
- R11: When a step and an offset take effect on the same clock, both are applied to the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
A write lands at the clock edge where it is strobed. A request raised by that write acts one edge later. For a load and an offset raised together, the offset acts two edges later. Read data appears one edge after the read strobe, and it holds the value the time had just before that edge. Counting only advances on edges where the registered run bit is already set. The run window therefore covers the edges after the starting control write, up to and including the stopping one. The bench lines up its expected step counts with that window. It issues writes and reads back to back at falling edges, so every sample is taken half a period after the edge that produced it.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int SEC_W  = 32;
  localparam int SUB_W  = 31;
  localparam int STEP_W = 8;
  localparam int REG_W  = 32;
  localparam int ADR_W  = 3;

  localparam logic [ADR_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [ADR_W-1:0] RA_STEP   = 3'd1;
  localparam logic [ADR_W-1:0] RA_SSEC   = 3'd2;
  localparam logic [ADR_W-1:0] RA_SSUB   = 3'd3;
  localparam logic [ADR_W-1:0] RA_SRATE  = 3'd4;
  localparam logic [ADR_W-1:0] RA_RATE   = 3'd5;
  localparam logic [ADR_W-1:0] RA_TSEC   = 3'd6;
  localparam logic [ADR_W-1:0] RA_TSUB   = 3'd7;

  localparam int CB_RUN  = 0;
  localparam int CB_FINE = 1;
  localparam int CB_LOAD = 2;
  localparam int CB_OFS  = 3;
  localparam int CB_RATE = 4;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
  } tod_t;

  // add a positive amount; subseconds sum of two values below 2^31 needs one carry
  function automatic tod_t tod_plus(tod_t a, logic [SEC_W-1:0] ds, logic [SUB_W-1:0] dsub);
    logic [SUB_W:0] s;
    tod_t r;
    s     = {1'b0, a.sub} + {1'b0, dsub};
    r.sub = s[SUB_W-1:0];
    r.sec = a.sec + ds + SEC_W'(s[SUB_W]);
    return r;
  endfunction

  // subtract a positive amount; a borrow wraps subseconds by 2^31
  function automatic tod_t tod_minus(tod_t a, logic [SEC_W-1:0] ds, logic [SUB_W-1:0] dsub);
    logic [SUB_W:0] d;
    tod_t r;
    d     = {1'b0, a.sub} - {1'b0, dsub};
    r.sub = d[SUB_W-1:0];
    r.sec = a.sec - ds - SEC_W'(d[SUB_W]);
    return r;
  endfunction

endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] rate,
  output logic             carry
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, rate};
  assign carry = en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tc_pkg::*;
#(
  parameter int STEP_BITS = STEP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [STEP_BITS-1:0] step,
  input  logic                 load_do,
  input  logic                 ofs_do,
  input  logic [SEC_W-1:0]     stage_sec,
  input  logic [REG_W-1:0]     stage_sub,
  output tod_t                 now
);
  localparam int SIGN_BIT = REG_W - 1;

  tod_t stepped, loaded, nxt;

  always_comb begin
    stepped = tick ? tod_plus(now, '0, SUB_W'(step)) : now;
    loaded  = '{sec: stage_sec, sub: stage_sub[SUB_W-1:0]};
    if (load_do)
      nxt = loaded;
    else if (ofs_do)
      nxt = stage_sub[SIGN_BIT] ? tod_minus(stepped, stage_sec, stage_sub[SUB_W-1:0])
                                : tod_plus(stepped, stage_sec, stage_sub[SUB_W-1:0]);
    else
      nxt = stepped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= nxt;
  end
endmodule

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int              RATE_W     = 32,
  parameter logic [RATE_W-1:0] DEF_ADDEND = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  tod_t              now,
  output logic              run,
  output logic              fine,
  output logic [STEP_W-1:0] step,
  output logic [SEC_W-1:0]  stage_sec,
  output logic [REG_W-1:0]  stage_sub,
  output logic [RATE_W-1:0] stage_rate,
  output logic [RATE_W-1:0] rate,
  output logic              load_do,
  output logic              ofs_do,
  output logic              rate_do
);
  logic load_pend, ofs_pend, rate_pend;
  logic ctrl_wr, time_lock;
  logic [SUB_W-1:0] snap_sub;

  assign ctrl_wr   = wr_en && (wr_addr == RA_CTRL);
  assign time_lock = load_pend | ofs_pend;
  assign load_do   = load_pend;
  assign ofs_do    = ofs_pend & ~load_pend;
  assign rate_do   = rate_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      fine       <= 1'b0;
      load_pend  <= 1'b0;
      ofs_pend   <= 1'b0;
      rate_pend  <= 1'b0;
      step       <= '0;
      stage_sec  <= '0;
      stage_sub  <= '0;
      stage_rate <= DEF_ADDEND;
      rate       <= DEF_ADDEND;
    end else begin
      load_pend <= ctrl_wr && wr_data[CB_LOAD] && !load_pend;
      ofs_pend  <= ofs_do ? 1'b0 : (ofs_pend | (ctrl_wr & wr_data[CB_OFS]));
      rate_pend <= ctrl_wr && wr_data[CB_RATE] && !rate_pend;
      if (rate_do) rate <= stage_rate;
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL: begin
            run  <= wr_data[CB_RUN];
            fine <= wr_data[CB_FINE];
          end
          RA_STEP:  step <= wr_data[STEP_W-1:0];
          RA_SSEC:  if (!time_lock) stage_sec <= wr_data[SEC_W-1:0];
          RA_SSUB:  if (!time_lock) stage_sub <= wr_data;
          RA_SRATE: if (!rate_pend) stage_rate <= wr_data[RATE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      snap_sub <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        RA_CTRL:  rd_data <= REG_W'({rate_pend, ofs_pend, load_pend, fine, run});
        RA_STEP:  rd_data <= REG_W'(step);
        RA_SSEC:  rd_data <= REG_W'(stage_sec);
        RA_SSUB:  rd_data <= stage_sub;
        RA_SRATE: rd_data <= REG_W'(stage_rate);
        RA_RATE:  rd_data <= REG_W'(rate);
        RA_TSEC: begin
          rd_data  <= REG_W'(now.sec);
          snap_sub <= now.sub;
        end
        default:  rd_data <= REG_W'(snap_sub);
      endcase
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int                RATE_W     = 32,
  parameter logic [RATE_W-1:0] DEF_ADDEND = 32'h4000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [REG_W-1:0] rd_data
);
  logic              run, fine, carry, tick;
  logic              load_do, ofs_do, rate_do;
  logic [STEP_W-1:0] step;
  logic [SEC_W-1:0]  stage_sec;
  logic [REG_W-1:0]  stage_sub;
  logic [RATE_W-1:0] stage_rate, rate;
  tod_t              now;

  assign tick = run & (fine ? carry : 1'b1);

  ptp_tc_regs #(.RATE_W(RATE_W), .DEF_ADDEND(DEF_ADDEND)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .now(now), .run(run), .fine(fine), .step(step),
    .stage_sec(stage_sec), .stage_sub(stage_sub), .stage_rate(stage_rate),
    .rate(rate), .load_do(load_do), .ofs_do(ofs_do), .rate_do(rate_do)
  );

  ptp_rate_accum #(.ACC_W(RATE_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en(run & fine), .rate(rate), .carry(carry)
  );

  ptp_tod_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
    .load_do(load_do), .ofs_do(ofs_do),
    .stage_sec(stage_sec), .stage_sub(stage_sub), .now(now)
  );
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk
  import ptp_tc_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              fine,
  input logic              tick,
  input logic              load_do,
  input logic              ofs_do,
  input logic              rate_do,
  input logic [STEP_W-1:0] step,
  input logic [SEC_W-1:0]  stage_sec,
  input logic [REG_W-1:0]  stage_sub,
  input logic [RATE_W-1:0] stage_rate,
  input logic [RATE_W-1:0] rate,
  input tod_t              now
);
  localparam logic [SUB_W-1:0] NEAR_TOP = {SUB_W{1'b1}} - SUB_W'(256);

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_do && !ofs_do) |=> $stable(now));                          // R4
  AST_FINE_WAITS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fine && !tick && !load_do && !ofs_do) |=> $stable(now));          // R2
  AST_COARSE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fine && !load_do && !ofs_do && now.sub < NEAR_TOP)
      |=> now.sub == $past(now.sub) + SUB_W'($past(step)));                    // R3
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load_do |=> (now.sec == $past(stage_sec)) && (now.sub == $past(stage_sub[SUB_W-1:0]))); // R6
  AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    load_do |=> !load_do);                                                     // R6
  AST_OFS_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_do && ofs_do) |-> 1'b0);                                             // R10
  AST_OFS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_do |=> !ofs_do);                                                       // R7
  AST_RATE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rate_do |=> (rate == $past(stage_rate)) && !rate_do);                      // R8
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fine(fine), .tick(tick),
  .load_do(load_do), .ofs_do(ofs_do), .rate_do(rate_do), .step(step),
  .stage_sec(stage_sec), .stage_sub(stage_sub), .stage_rate(stage_rate),
  .rate(rate), .now(now)
);

// File: tb/ptp_time_counter_test.sv
`timescale 1ns/1ps
module ptp_time_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptp_time_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [31:0] s0_sec, s0_sub, d_sec, d_sub, e_sec, e_sub;
  } ofs_vec_t;

  localparam int NV = 7;
  localparam ofs_vec_t VEC [NV] = '{
    '{32'd10,         32'd100,        32'd2, 32'd50,         32'd12,         32'd150},
    '{32'd10,         32'h7FFF_FFF6,  32'd0, 32'd20,         32'd11,         32'd10},
    '{32'd10,         32'd5,          32'd0, 32'h8000_000A,  32'd9,          32'h7FFF_FFFB},
    '{32'd10,         32'd5,          32'd3, 32'h8000_0005,  32'd7,          32'd0},
    '{32'd0,          32'd0,          32'd0, 32'h8000_0001,  32'hFFFF_FFFF,  32'h7FFF_FFFF},
    '{32'hFFFF_FFFF,  32'h7FFF_FFF0,  32'd0, 32'h20,         32'd0,          32'h10},
    '{32'd3,          32'h100,        32'd1, 32'h8000_0200,  32'd1,          32'h7FFF_FF00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge; each covers one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_time(input string req, input logic [31:0] es, input logic [31:0] eu);
    logic [31:0] v;
    rd(3'd6, v); check(req, v, es);
    rd(3'd7, v); check(req, v, eu);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check_time("R1 time", 32'd0, 32'd0);
    rd(3'd0, v); check("R1 ctrl", v, 32'd0);
    rd(3'd5, v); check("R1 rate", v, 32'h4000_0000);

    // R2 fine mode: 8 adds of 2^30 give 2 carries
    wr(3'd1, 32'd10);
    wr(3'd0, 32'h3);
    idle(7);
    wr(3'd0, 32'h0);
    check_time("R2 fine default rate", 32'd0, 32'd20);

    // R8 rate update, then R2 with 0xC000_0000: 4 adds give 3 carries
    wr(3'd4, 32'hC000_0000);
    wr(3'd0, 32'h10);
    idle(1);
    rd(3'd5, v); check("R8 rate loaded", v, 32'hC000_0000);
    rd(3'd0, v); check("R8 request cleared", v, 32'd0);
    wr(3'd0, 32'h3);
    idle(3);
    wr(3'd0, 32'h0);
    check_time("R2 fine trimmed rate", 32'd0, 32'd50);

    // R4 not enabled: fine selected but run clear
    wr(3'd0, 32'h2);
    idle(5);
    wr(3'd0, 32'h0);
    check_time("R4 halted", 32'd0, 32'd50);

    // R7 / R5 offset table
    for (int i = 0; i < NV; i++) begin
      wr(3'd2, VEC[i].s0_sec);
      wr(3'd3, VEC[i].s0_sub);
      wr(3'd0, 32'h4);
      idle(1);
      wr(3'd2, VEC[i].d_sec);
      wr(3'd3, VEC[i].d_sub);
      wr(3'd0, 32'h8);
      idle(1);
      check_time($sformatf("R7 R5 offset vector %0d", i), VEC[i].e_sec, VEC[i].e_sub);
    end

    // R6 load with self-clearing request
    wr(3'd2, 32'd77);
    wr(3'd3, 32'd5);
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R6 request pending", v, 32'h4);
    rd(3'd0, v); check("R6 request cleared", v, 32'h0);
    check_time("R6 loaded time", 32'd77, 32'd5);

    // R8 staged rate write ignored while request pending
    wr(3'd4, 32'h1111_1111);
    wr(3'd0, 32'h10);
    wr(3'd4, 32'h2222_2222);
    idle(1);
    rd(3'd5, v); check("R8 active rate", v, 32'h1111_1111);
    rd(3'd4, v); check("R8 staged locked", v, 32'h1111_1111);
    wr(3'd4, 32'h2222_2222);
    rd(3'd4, v); check("R8 staged unlocked", v, 32'h2222_2222);

    // R10 load and offset together: load, then offset by the same staged value
    wr(3'd2, 32'd20);
    wr(3'd3, 32'd100);
    wr(3'd0, 32'hC);
    idle(2);
    check_time("R10 load then offset", 32'd40, 32'd200);

    // R9 coherent pair, R3 coarse stepping, R5 carry from stepping
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd5);
    wr(3'd3, 32'h7FFF_FFFD);
    wr(3'd0, 32'h4);
    idle(1);
    wr(3'd0, 32'h1);
    rd(3'd6, v); check("R9 seconds", v, 32'd5);
    rd(3'd7, v); check("R9 frozen subseconds", v, 32'h7FFF_FFFD);
    wr(3'd0, 32'h0);
    rd(3'd7, v); check("R9 still frozen", v, 32'h7FFF_FFFD);
    check_time("R3 R5 coarse three steps", 32'd6, 32'd0);

    // R11 step and offset on the same clock
    wr(3'd1, 32'd8);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h7FFF_FFFC);
    wr(3'd0, 32'h4);
    idle(1);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h9);
    wr(3'd0, 32'h0);
    check_time("R11 step plus offset", 32'd4, 32'd6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule